// File: doc/BRIEF.md
# Bidirectional Nominal Shift Unit

This functional unit moves a 60-bit operand left or right by a distance that comes from one of two places. In the two constant forms the distance is a two-octal-digit number made by joining two 3-bit instruction fields. In the two register forms the distance is a signed 18-bit count read from an index register. A negative register count turns the shift around: the unit shifts the other way by the count's magnitude. Left shifts bring in zeros. Right shifts are arithmetic and copy bit 59 into the vacated positions.

An operation enters through a valid/ready handshake. The unit holds one operation at a time. It lowers `in_ready` for the two cycles after it accepts an operation, and raises it again in the cycle that delivers the result. The output has no back-pressure. `done` is a single-cycle pulse that marks a fresh `result`. The consumer must take the result in that cycle, or read it later, because `result` holds its value until the next `done`.

Top module: `nshift_unit`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `in_ready` is 1.
- R2: Operation code 2'b00 shifts the operand left by the unsigned 6-bit count {in_j, in_k}, with in_j as the high three bits and zeros filling from the right.
- R3: Operation code 2'b01 shifts the operand right by {in_j, in_k}, copying bit 59 into the vacated high bits.
- R4: Operation code 2'b10 shifts left by the value of the two's-complement `in_bcnt`. When `in_bcnt` is negative, it shifts right arithmetically by the magnitude instead.
- R5: Operation code 2'b11 shifts right arithmetically by `in_bcnt`. When `in_bcnt` is negative, it shifts left by the magnitude instead.
- R6: A count magnitude of 60 or more gives all zeros for a left shift and 60 copies of bit 59 for a right shift. This includes the magnitude 131072 that comes from `in_bcnt` = -131072.
- R7: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its `done` pulse is high for exactly the one cycle beginning on the third rising edge after that edge. `result` changes only on the edge that raises `done`.
- R8: `in_ready` is 0 for the two cycles after an acceptance, and `in_valid` is ignored during those cycles. `in_ready` is 1 again in the `done` cycle, so a new operation can be accepted there.
- R9: A count of zero, in either form, returns the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 2 | Operation code: 00 const left, 01 const right, 10 nominal left, 11 nominal right |
| in_j | input | 3 | High octal digit of the constant count |
| in_k | input | 3 | Low octal digit of the constant count |
| in_bcnt | input | 18 | Signed count for the register forms |
| in_x | input | 60 | Operand |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 60 | Shifted value, held until the next `done` |

## Verification
Delivery of one result and acceptance of the next operation can fall in the same cycle. The bench provokes this by keeping `in_valid` high with a second operation through the first operation's `done` cycle. It then checks that the first result is correct in that cycle and that the second `done` arrives exactly three cycles later with its own value. A separate scenario offers an operation while `in_ready` is low and withdraws it before the `done` cycle. The bench judges that case by the held `result` and by the absence of any extra `done` pulse.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
  typedef enum logic [1:0] {
    OP_CONST_L = 2'b00,
    OP_CONST_R = 2'b01,
    OP_REG_L   = 2'b10,
    OP_REG_R   = 2'b11
  } nsu_op_e;
endpackage

// File: rtl/nsu_decode.sv
module nsu_decode #(
  parameter int W  = 60,
  parameter int FW = 3,
  parameter int BW = 18,
  localparam int SW = $clog2(W)
) (
  input  logic [1:0]    op,
  input  logic [FW-1:0] fj,
  input  logic [FW-1:0] fk,
  input  logic [BW-1:0] bcnt,
  output logic          go_left,
  output logic          sat,
  output logic [SW-1:0] amt
);
  import nsu_pkg::*;
  logic [BW-1:0] mag;
  logic          neg;

  always_comb begin
    neg = bcnt[BW-1];
    if (op[1] == 1'b0) begin
      // constant forms: two fields joined, j high
      mag     = {{(BW-2*FW){1'b0}}, fj, fk};
      go_left = (nsu_op_e'(op) == OP_CONST_L);
    end else begin
      mag     = neg ? (~bcnt + 1'b1) : bcnt;
      // negative count reverses the nominal direction
      go_left = neg ? op[0] : ~op[0];
    end
    sat = (mag >= BW'(W));
    amt = mag[SW-1:0];
  end
endmodule

// File: rtl/nsu_barrel.sv
module nsu_barrel #(
  parameter int W = 60,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic          go_left,
  input  logic          sat,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  y
);
  logic [W-1:0] lvl [SW+1];
  logic         sgn;

  assign sgn    = x[W-1];
  assign lvl[0] = x;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int SH = 1 << i;
    logic [W-1:0] shl, shr;
    assign shl = {lvl[i][W-1-SH:0], {SH{1'b0}}};
    assign shr = {{SH{sgn}}, lvl[i][W-1:SH]};
    assign lvl[i+1] = amt[i] ? (go_left ? shl : shr) : lvl[i];
  end

  assign y = sat ? (go_left ? '0 : {W{sgn}}) : lvl[SW];
endmodule

// File: rtl/nshift_unit.sv
module nshift_unit #(
  parameter int W  = 60,
  parameter int FW = 3,
  parameter int BW = 18,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [FW-1:0] in_j,
  input  logic [FW-1:0] in_k,
  input  logic [BW-1:0] in_bcnt,
  input  logic [W-1:0]  in_x,
  output logic          done,
  output logic [W-1:0]  result
);
  logic          accept;
  logic [2:0]    vld;
  logic          d_left, d_sat;
  logic [SW-1:0] d_amt;
  logic          s1_left, s1_sat;
  logic [SW-1:0] s1_amt;
  logic [W-1:0]  s1_x, sh_y, s2_y;

  assign in_ready = ~vld[0] & ~vld[1];
  assign accept   = in_valid & in_ready;
  assign done     = vld[2];

  nsu_decode #(.W(W), .FW(FW), .BW(BW)) u_dec (
    .op(in_op), .fj(in_j), .fk(in_k), .bcnt(in_bcnt),
    .go_left(d_left), .sat(d_sat), .amt(d_amt)
  );

  nsu_barrel #(.W(W)) u_bar (
    .x(s1_x), .go_left(s1_left), .sat(s1_sat), .amt(s1_amt), .y(sh_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      s1_x    <= '0;
      s1_left <= 1'b0;
      s1_sat  <= 1'b0;
      s1_amt  <= '0;
      s2_y    <= '0;
      result  <= '0;
    end else begin
      vld <= {vld[1:0], accept};
      if (accept) begin
        s1_x    <= in_x;
        s1_left <= d_left;
        s1_sat  <= d_sat;
        s1_amt  <= d_amt;
      end
      if (vld[0]) s2_y   <= sh_y;
      if (vld[1]) result <= s2_y;
    end
  end

  // R7: done arrives on the third edge after acceptance
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##2 done);
  // R7: done lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: result moves only with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  // R8: not ready for two cycles after acceptance
  a_r8_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready ##1 !in_ready);
endmodule

// File: tb/nshift_unit_tb.sv
module nshift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_j = '0, in_k = '0;
  logic [17:0] in_bcnt = '0;
  logic [59:0] in_x = '0;
  logic        done;
  logic [59:0] result;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nshift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_j(in_j), .in_k(in_k), .in_bcnt(in_bcnt),
    .in_x(in_x), .done(done), .result(result)
  );

  function automatic logic [59:0] model(input logic [1:0] op, input logic [2:0] j,
      input logic [2:0] k, input logic [17:0] b, input logic [59:0] x);
    int n; bit left;
    logic signed [59:0] sx;
    if (!op[1]) begin
      n = {j, k};
      left = (op == 2'b00);
    end else begin
      n = int'($signed(b));
      left = (op == 2'b10);
      if (n < 0) begin n = -n; left = !left; end
    end
    sx = x;
    if (left) return (n >= 60) ? 60'd0 : (x << n);
    return (n >= 60) ? {60{x[59]}} : 60'(sx >>> n);
  endfunction

  task automatic check(input string tag, input logic [59:0] act, input logic [59:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [2:0] j, input logic [2:0] k,
      input logic [17:0] b, input logic [59:0] x);
    in_valid = 1'b1; in_op = op; in_j = j; in_k = k; in_bcnt = b; in_x = x;
  endtask

  // one operation from an idle unit, full timing check
  task automatic run_op(input string tag, input logic [1:0] op, input logic [2:0] j,
      input logic [2:0] k, input logic [17:0] b, input logic [59:0] x);
    logic [59:0] exp;
    exp = model(op, j, k, b, x);
    @(negedge clk); drive(op, j, k, b, x);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    check({tag, " R8 busy"}, {59'd0, in_ready}, 60'd0);
    check({tag, " R7 early"}, {59'd0, done}, 60'd0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check({tag, " R7 done"}, {59'd0, done}, 60'd1);
    check({tag, " value"}, result, exp);
    @(posedge clk); @(negedge clk);
    check({tag, " R7 pulse end"}, {59'd0, done}, 60'd0);
    check({tag, " R7 hold"}, result, exp);
  endtask

  task automatic t_reset;
    check("R1 done", {59'd0, done}, 60'd0);
    check("R1 result", result, 60'd0);
    check("R1 ready", {59'd0, in_ready}, 60'd1);
  endtask

  task automatic t_zero;
    run_op("R9 const zero", 2'b00, 3'd0, 3'd0, 18'd0, 60'h0AB_CDEF_0123_4567);
    run_op("R9 reg zero", 2'b11, 3'd0, 3'd0, 18'd0, 60'h800_0000_0000_0001);
  endtask

  task automatic t_const;
    run_op("R2 63<<13", 2'b00, 3'd1, 3'd5, 18'd0, 60'd63);
    check("R2 literal", result, 60'd516096);
    run_op("R2 j high", 2'b00, 3'd7, 3'd3, 18'd0, 60'd1);
    run_op("R3 neg right", 2'b01, 3'd0, 3'd3, 18'd0, -60'sd1000);
    check("R3 literal", result, -60'sd125);
    run_op("R3 pos right", 2'b01, 3'd2, 3'd3, 18'd0, 60'd2125920);
  endtask

  task automatic t_reg;
    run_op("R4 left 4", 2'b10, 3'd0, 3'd0, 18'd4, 60'd2060);
    check("R4 literal", result, 60'd32960);
    run_op("R4 neg -3", 2'b10, 3'd0, 3'd0, -18'sd3, 60'd1032);
    check("R4 literal -3", result, 60'd129);
    run_op("R5 right 4", 2'b11, 3'd0, 3'd0, 18'd4, 60'd131);
    check("R5 literal", result, 60'd8);
    run_op("R5 neg -2", 2'b11, 3'd0, 3'd0, -18'sd2, 60'd7);
    check("R5 literal -2", result, 60'd28);
  endtask

  task automatic t_sat;
    run_op("R6 const left 63", 2'b00, 3'd7, 3'd7, 18'd0, 60'hFFF_FFFF_FFFF_FFFF);
    check("R6 zero fill", result, 60'd0);
    run_op("R6 const right 63", 2'b01, 3'd7, 3'd7, 18'd0, 60'h800_0000_0000_0000);
    check("R6 sign fill", result, {60{1'b1}});
    run_op("R6 reg right 60", 2'b11, 3'd0, 3'd0, 18'd60, 60'h7FF_FFFF_FFFF_FFFF);
    run_op("R6 min count", 2'b11, 3'd0, 3'd0, 18'h20000, 60'd5);
    run_op("R6 edge 59", 2'b10, 3'd0, 3'd0, 18'd59, 60'd1);
  endtask

  // second op accepted in the first op's done cycle
  task automatic t_overlap;
    logic [59:0] ea, eb;
    ea = model(2'b00, 3'd0, 3'd4, 18'd0, 60'd3);
    eb = model(2'b10, 3'd0, 3'd0, -18'sd1, 60'd10);
    @(negedge clk); drive(2'b00, 3'd0, 3'd4, 18'd0, 60'd3);
    @(posedge clk); @(negedge clk); drive(2'b10, 3'd0, 3'd0, -18'sd1, 60'd10);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R8 ready in done cycle", {59'd0, in_ready}, 60'd1);
    check("R7 overlap first done", {59'd0, done}, 60'd1);
    check("R7 overlap first value", result, ea);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    check("R8 second accepted", {59'd0, in_ready}, 60'd0);
    @(posedge clk); @(negedge clk);
    check("R7 overlap gap", {59'd0, done}, 60'd0);
    @(posedge clk); @(negedge clk);
    check("R7 overlap second done", {59'd0, done}, 60'd1);
    check("R7 overlap second value", result, eb);
  endtask

  // offer while busy, withdraw before ready: must be ignored
  task automatic t_ignore;
    logic [59:0] ea;
    ea = model(2'b01, 3'd0, 3'd1, 18'd0, 60'd40);
    @(negedge clk); drive(2'b01, 3'd0, 3'd1, 18'd0, 60'd40);
    @(posedge clk); @(negedge clk); drive(2'b00, 3'd0, 3'd2, 18'd0, 60'd99);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    check("R8 ignored first value", result, ea);
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); @(negedge clk);
      check("R8 no extra done", {59'd0, done}, 60'd0);
    end
    check("R8 result kept", result, ea);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_zero();
    t_const();
    t_reg();
    t_sat();
    t_overlap();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule